// File: doc/BRIEF.md
# Tagged Pointer Register Bank with Address Resolution

This block holds four 32-bit pointer registers, each with a shadow copy in a second bank, and turns the selected register into a 24-bit memory address. The upper half of each register acts as a tag. A tag of all ones marks a 16-bit logical address. That address is mapped through a small page table, and the table has one copy for instruction fetches and one for data accesses. Any other tag marks a physical address, and its low 24 bits drive the address output directly. This keeps older 20-bit addresses usable without change.

The surrounding pipeline loads registers as full 32-bit words or as 16-bit logical pointers. It can exchange the two banks. It can also ask the block to convert a logical pointer in place into its physical form. The conversion raises a one-cycle dummy-read strobe, so memory observes an access at the logical address, and the translated address is written back into the same register.

Top module: `ptr_resolver`

## Requirements
- R1: After reset, every register in both banks reads 0xFFFF0000. Both page tables map page p to base p, so the address output is 0x000000 with `addrLogical` = 1.
- R2: Operation code 1 (32-bit load) writes `wrData` into the selected register of the active bank. The new value can be read from the next cycle.
- R3: Operation code 2 (16-bit load) writes `wrData[15:0]` into the low half of the selected register and forces the high half to 0xFFFF.
- R4: When bits [31:16] of the selected register are 0xFFFF, `addrLogical` is 1. `addrOut` is then the 12-bit page base indexed by register bits [15:12], followed by register bits [11:0].
- R5: When bits [31:16] of the selected register hold any other value, `addrLogical` is 0 and `addrOut` equals register bits [23:0]. Neither page table affects the result.
- R6: `isCode` = 1 selects the code page table and `isCode` = 0 selects the data page table. The two tables are independent.
- R7: A table write (`tblWe` = 1) stores `tblBase` at entry `tblIdx` of the table chosen by `tblCode`. The entry takes effect from the next cycle.
- R8: Operation code 3 (convert) on a logical pointer drives `dummyRd` high for that cycle only, with `addrOut` showing the translated address. After the clock edge the register holds 0x00 followed by that 24-bit address.
- R9: Operation code 3 on a physical pointer leaves `dummyRd` low and leaves the register unchanged.
- R10: Operation code 4 (swap) exchanges the active and shadow banks. A second swap restores the earlier view, and each bank keeps its own contents.
- R11: The four registers are independent. A write to one register leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 idle, 1 load32, 2 load16, 3 convert, 4 swap |
| regSel | input | 2 | Index of the pointer register |
| isCode | input | 1 | Translation space: 1 code, 0 data |
| wrData | input | 32 | Load data |
| tblWe | input | 1 | Page table write enable |
| tblCode | input | 1 | Table to write: 1 code, 0 data |
| tblIdx | input | 4 | Page table entry index |
| tblBase | input | 12 | Page base value to write |
| rdData | output | 32 | Selected register contents |
| addrOut | output | 24 | Resolved physical address |
| addrLogical | output | 1 | Selected register is tagged logical |
| dummyRd | output | 1 | One-cycle dummy read strobe during a conversion |

## Verification
`rdData`, `addrOut`, `addrLogical` and `dummyRd` are combinational from the registers and the current inputs. The strobe and the resolved address therefore belong to the same cycle in which a convert operation is presented, and the bench samples them one time unit after the falling edge on which it drove that operation. Loads, conversions, swaps and table writes change state at the next rising edge. Their results are sampled at the following falling edge, after the operation has been returned to idle and with `regSel` and `isCode` still held.

// File: rtl/ptr_resolver_pkg.sv
package ptr_resolver_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_LD32 = 3'd1,
    OP_LD16 = 3'd2,
    OP_CVT  = 3'd3,
    OP_SWAP = 3'd4
  } ptrOp_e;

  // control to datapath strobes
  typedef struct packed {
    logic ld32;
    logic ld16;
    logic cvtWr;
    logic swap;
  } ptrStrobes_t;
endpackage

// File: rtl/ptr_resolver_ctrl.sv
module ptr_resolver_ctrl
  import ptr_resolver_pkg::*;
(
  input  logic [2:0]  op,
  input  logic        addrLogical,
  output ptrStrobes_t stb,
  output logic        dummyRd
);
  always_comb begin
    stb = '0;
    case (op)
      OP_LD32: stb.ld32  = 1'b1;
      OP_LD16: stb.ld16  = 1'b1;
      OP_CVT:  stb.cvtWr = addrLogical;  // physical pointers stay as they are
      OP_SWAP: stb.swap  = 1'b1;
      default: stb = '0;
    endcase
  end

  assign dummyRd = stb.cvtWr;
endmodule

// File: rtl/ptr_resolver_dp.sv
module ptr_resolver_dp
  import ptr_resolver_pkg::*;
#(
  parameter int PTR_W   = 32,
  parameter int LOG_W   = 16,
  parameter int PHYS_W  = 24,
  parameter int NUM_PTR = 4,
  parameter int PAGE_W  = 4,
  localparam int SEL_W  = $clog2(NUM_PTR),
  localparam int OFF_W  = LOG_W - PAGE_W,
  localparam int BASE_W = PHYS_W - OFF_W,
  localparam int TAG_W  = PTR_W - LOG_W,
  localparam int PAGES  = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobes_t       stb,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              isCode,
  input  logic [PTR_W-1:0]  wrData,
  input  logic              tblWe,
  input  logic              tblCode,
  input  logic [PAGE_W-1:0] tblIdx,
  input  logic [BASE_W-1:0] tblBase,
  output logic [PTR_W-1:0]  rdData,
  output logic [PHYS_W-1:0] addrOut,
  output logic              addrLogical
);
  localparam logic [PTR_W-1:0] RESET_VAL = {{TAG_W{1'b1}}, {LOG_W{1'b0}}};

  logic [PTR_W-1:0]  ptrBank [2][NUM_PTR];
  logic              bankSel;
  logic [PTR_W-1:0]  curPtr;
  logic [BASE_W-1:0] spaceBase [2];
  logic [PHYS_W-1:0] transAddr;

  assign curPtr      = ptrBank[bankSel][regSel];
  assign addrLogical = (curPtr[PTR_W-1:LOG_W] == {TAG_W{1'b1}});
  assign transAddr   = {spaceBase[isCode], curPtr[OFF_W-1:0]};
  assign addrOut     = addrLogical ? transAddr : curPtr[PHYS_W-1:0];
  assign rdData      = curPtr;

  // page tables: index 0 = data space, index 1 = code space
  for (genvar s = 0; s < 2; s++) begin : gSpace
    logic [BASE_W-1:0] pageBase [PAGES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int p = 0; p < PAGES; p++) pageBase[p] <= BASE_W'(p);
      end else if (tblWe && (tblCode == 1'(s))) begin
        pageBase[tblIdx] <= tblBase;
      end
    end

    assign spaceBase[s] = pageBase[curPtr[LOG_W-1:OFF_W]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_PTR; i++) ptrBank[b][i] <= RESET_VAL;
    end else begin
      if (stb.swap) bankSel <= ~bankSel;
      if (stb.ld32)
        ptrBank[bankSel][regSel] <= wrData;
      else if (stb.ld16)
        ptrBank[bankSel][regSel] <= {{TAG_W{1'b1}}, wrData[LOG_W-1:0]};
      else if (stb.cvtWr)
        ptrBank[bankSel][regSel] <= {{(PTR_W-PHYS_W){1'b0}}, transAddr};
    end
  end
endmodule

// File: rtl/ptr_resolver.sv
module ptr_resolver
  import ptr_resolver_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  op,
  input  logic [1:0]  regSel,
  input  logic        isCode,
  input  logic [31:0] wrData,
  input  logic        tblWe,
  input  logic        tblCode,
  input  logic [3:0]  tblIdx,
  input  logic [11:0] tblBase,
  output logic [31:0] rdData,
  output logic [23:0] addrOut,
  output logic        addrLogical,
  output logic        dummyRd
);
  ptrStrobes_t stb;

  ptr_resolver_ctrl uCtrl (
    .op          (op),
    .addrLogical (addrLogical),
    .stb         (stb),
    .dummyRd     (dummyRd)
  );

  ptr_resolver_dp #(
    .PTR_W   (32),
    .LOG_W   (16),
    .PHYS_W  (24),
    .NUM_PTR (4),
    .PAGE_W  (4)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .regSel      (regSel),
    .isCode      (isCode),
    .wrData      (wrData),
    .tblWe       (tblWe),
    .tblCode     (tblCode),
    .tblIdx      (tblIdx),
    .tblBase     (tblBase),
    .rdData      (rdData),
    .addrOut     (addrOut),
    .addrLogical (addrLogical)
  );
endmodule

// File: rtl/ptr_resolver_chk.sv
module ptr_resolver_chk
  import ptr_resolver_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  op,
  input logic [1:0]  regSel,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [23:0] addrOut,
  input logic        addrLogical,
  input logic        dummyRd
);
  assert_load32_R2: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_LD32) |=> (!$stable(regSel) || rdData == $past(wrData)));

  assert_load16_tag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_LD16) |=> (!$stable(regSel) ||
      rdData == {16'hFFFF, $past(wrData[15:0])}));

  assert_phys_bypass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[31:16] != 16'hFFFF) |-> (!addrLogical && addrOut == rdData[23:0]));

  assert_dummy_only_cvt_R8: assert property (@(posedge clk) disable iff (!rstN)
    dummyRd |-> (op == OP_CVT && addrLogical));

  assert_cvt_writeback_R8: assert property (@(posedge clk) disable iff (!rstN)
    dummyRd |=> (!$stable(regSel) || rdData == {8'h00, $past(addrOut)}));

  assert_cvt_phys_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_CVT && !addrLogical) |-> !dummyRd);

  assert_cvt_phys_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_CVT && !addrLogical) |=> (!$stable(regSel) || $stable(rdData)));
endmodule

bind ptr_resolver ptr_resolver_chk uChk (.*);

// File: tb/ptr_resolver_test.sv
`timescale 1ns/1ps
module ptr_resolver_test;
  import ptr_resolver_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  op = OP_IDLE;
  logic [1:0]  regSel = '0;
  logic        isCode = 1'b0;
  logic [31:0] wrData = '0;
  logic        tblWe = 1'b0;
  logic        tblCode = 1'b0;
  logic [3:0]  tblIdx = '0;
  logic [11:0] tblBase = '0;
  logic [31:0] rdData;
  logic [23:0] addrOut;
  logic        addrLogical;
  logic        dummyRd;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ptr_resolver uut (.*);

  typedef struct packed {
    logic [2:0]  vOp;
    logic [1:0]  vSel;
    logic        vCode;
    logic [31:0] vWr;
    logic [31:0] expRd;
    logic [23:0] expAddr;
    logic        expLog;
  } vec_t;

  // identity tables throughout the vector walk
  localparam vec_t VECS [9] = '{
    '{OP_LD32, 2'd0, 1'b0, 32'h12345678, 32'h12345678, 24'h345678, 1'b0},  // R2 R5
    '{OP_LD16, 2'd1, 1'b0, 32'hAAAABEEF, 32'hFFFFBEEF, 24'h00BEEF, 1'b1},  // R3 R4
    '{OP_LD32, 2'd2, 1'b1, 32'hFFFF1234, 32'hFFFF1234, 24'h001234, 1'b1},  // R2 R4
    '{OP_LD32, 2'd3, 1'b0, 32'h00ABCDEF, 32'h00ABCDEF, 24'hABCDEF, 1'b0},  // R5
    '{OP_CVT,  2'd1, 1'b0, 32'h0,        32'h0000BEEF, 24'h00BEEF, 1'b0},  // R8
    '{OP_CVT,  2'd0, 1'b0, 32'h0,        32'h12345678, 24'h345678, 1'b0},  // R9
    '{OP_IDLE, 2'd2, 1'b0, 32'h0,        32'hFFFF1234, 24'h001234, 1'b1},  // R4
    '{OP_LD16, 2'd3, 1'b0, 32'h00000042, 32'hFFFF0042, 24'h000042, 1'b1},  // R3
    '{OP_LD32, 2'd0, 1'b1, 32'h000FFFFF, 32'h000FFFFF, 24'h0FFFFF, 1'b0}   // R5 20-bit
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] o, input logic [1:0] s, input logic c,
                      input logic [31:0] d);
    @(negedge clk);
    op = o; regSel = s; isCode = c; wrData = d;
    @(negedge clk);
    op = OP_IDLE;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      regSel = 2'(i);
      #1;
      check("R1 rdData", rdData, 32'hFFFF0000);
      check("R1 addrOut", 32'(addrOut), 32'h0);
      check("R1 logical", 32'(addrLogical), 32'h1);
    end

    for (int v = 0; v < 9; v++) begin
      doOp(VECS[v].vOp, VECS[v].vSel, VECS[v].vCode, VECS[v].vWr);
      check($sformatf("vec%0d rdData R2/R3/R8/R9", v), rdData, VECS[v].expRd);
      check($sformatf("vec%0d addrOut R4/R5", v), 32'(addrOut), 32'(VECS[v].expAddr));
      check($sformatf("vec%0d logical R4/R5", v), 32'(addrLogical), 32'(VECS[v].expLog));
    end

    // R11 independent registers
    regSel = 2'd0; #1; check("R11 reg0", rdData, 32'h000FFFFF);
    regSel = 2'd1; #1; check("R11 reg1", rdData, 32'h0000BEEF);
    regSel = 2'd2; #1; check("R11 reg2", rdData, 32'hFFFF1234);
    regSel = 2'd3; #1; check("R11 reg3", rdData, 32'hFFFF0042);

    // R7 table writes, R6 separate spaces
    @(negedge clk);
    tblWe = 1'b1; tblCode = 1'b1; tblIdx = 4'hB; tblBase = 12'h7A3;
    @(negedge clk);
    tblCode = 1'b0; tblBase = 12'h155;
    @(negedge clk);
    tblWe = 1'b0;
    doOp(OP_LD16, 2'd2, 1'b1, 32'h0000B123);
    check("R6 R7 code space", 32'(addrOut), 32'h007A3123);
    isCode = 1'b0; #1;
    check("R6 R7 data space", 32'(addrOut), 32'h00155123);
    // R5 physical pointer ignores tables
    regSel = 2'd0; #1;
    check("R5 data table ignored", 32'(addrOut), 32'h000FFFFF);
    isCode = 1'b1; #1;
    check("R5 code table ignored", 32'(addrOut), 32'h000FFFFF);

    // R8 convert logical pointer in code space
    @(negedge clk);
    op = OP_CVT; regSel = 2'd2; isCode = 1'b1;
    #1;
    check("R8 strobe high", 32'(dummyRd), 32'h1);
    check("R8 address during convert", 32'(addrOut), 32'h007A3123);
    @(negedge clk);
    op = OP_IDLE;
    #1;
    check("R8 strobe one cycle", 32'(dummyRd), 32'h0);
    check("R8 written back", rdData, 32'h007A3123);
    // R9 convert again, now physical
    @(negedge clk);
    op = OP_CVT;
    #1;
    check("R9 no strobe", 32'(dummyRd), 32'h0);
    @(negedge clk);
    op = OP_IDLE;
    #1;
    check("R9 unchanged", rdData, 32'h007A3123);

    // R10 bank swap
    doOp(OP_SWAP, 2'd0, 1'b0, 32'h0);
    check("R10 shadow reset value", rdData, 32'hFFFF0000);
    doOp(OP_LD32, 2'd0, 1'b0, 32'hCAFEF00D);
    check("R10 shadow loaded", rdData, 32'hCAFEF00D);
    doOp(OP_SWAP, 2'd0, 1'b0, 32'h0);
    check("R10 primary restored", rdData, 32'h000FFFFF);
    regSel = 2'd1; #1;
    check("R10 primary reg1 kept", rdData, 32'h0000BEEF);
    doOp(OP_SWAP, 2'd0, 1'b0, 32'h0);
    check("R10 shadow kept", rdData, 32'hCAFEF00D);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule